// File: doc/BRIEF.md
# Strided Vector Load Bank Scheduler

This block runs one vector load. A start pulse supplies a base address, a signed stride and an element count. The block works out the address of every element. It sends the requests one at a time, in element order, to an interleaved memory made of sixteen independent banks. The bank that serves an address is chosen by the low four address bits. A bank that has just taken a request stays occupied for a few cycles. When the next element maps to an occupied bank, issue waits until that bank is free again. As a result, the issue rate depends on how the stride spreads over the banks.

The memory returns each word a fixed number of cycles after its request. Requests leave in element order, so words also come back in element order. The block marks each returning word with its element index, which the vector register file uses as the write position. A single-cycle done flag follows the final element. A load of length zero raises the done flag without sending any request.

Top module: `strided_load_sched`

## Requirements
- R1: Element i is requested at address base + i*stride, where stride is a signed 16-bit value and the sum wraps modulo 2^16. The element count is from 0 to 64.
- R2: The bank output of each request is the low 4 bits of that request's address.
- R3: A bank that accepts a request in cycle t accepts no other request before cycle t+4. While the next element's bank is occupied, issue waits and the element is not skipped.
- R4: When the stride is odd, so that it shares no factor with 16, the requests of one vector leave in consecutive cycles with no gap.
- R5: At most one request leaves per cycle, and requests leave in strictly rising element order.
- R6: After a start pulse captured at a clock edge, element 0 is requested in the next cycle. Its data is delivered 12 cycles after the request, so unit-stride startup is one read latency.
- R7: Every element is delivered exactly 12 cycles after its own request. It is delivered in element order, with elemIdx equal to its index and elemData equal to the word the memory returns in that cycle.
- R8: done is high for exactly one cycle, the cycle after the last element is delivered.
- R9: A start with element count 0 sends no request, and done rises in the cycle after the start.
- R10: During reset no request, delivery or done is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse; it is taken only while no load is running |
| baseAddr | input | 16 | Address of element 0 |
| stride | input | 16 | Signed distance between consecutive elements |
| vecLen | input | 7 | Element count, 0 to 64 |
| reqValid | output | 1 | A request leaves this cycle |
| reqAddr | output | 16 | Request address |
| reqBank | output | 4 | Bank that serves the request |
| rspData | input | 16 | Word returned by memory, valid 12 cycles after its request |
| elemValid | output | 1 | An element is delivered this cycle |
| elemIdx | output | 6 | Index of the delivered element |
| elemData | output | 16 | Data of the delivered element |
| done | output | 1 | One-cycle pulse after the last delivery |

## Verification
Each request is due in a cycle that the bench calculates without using the design. The first request is due one cycle after the start edge. Every later request is due at the later of two cycles: one cycle after the previous request, and four cycles after the last request to the same bank. The bench also calculates the address of each request. Each delivery is due exactly 12 cycles after its own request, and done is due one cycle after the final delivery, or one cycle after the start when the length is zero. All outputs are sampled on the falling edge. Each event seen is compared with the cycle number that the schedule predicts, so an issue that comes early or late, a missing stall, or a shifted latency shows up as a wrong cycle number.

// File: rtl/lsched_pkg.sv
package lsched_pkg;
  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic load;       // latch base and stride, a run begins
    logic issue;      // the current element leaves this cycle
    logic lastElem;   // the issued element is the final one
    logic emptyDone;  // zero-length start: finish at once
  } lschedStrobe_t;
endpackage

// File: rtl/lsched_bank_busy.sv
module lsched_bank_busy #(
  parameter int NUM_BANKS = 16,
  parameter int BUSY_CYC  = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         accept,
  input  logic [$clog2(NUM_BANKS)-1:0] acceptBank,
  output logic [NUM_BANKS-1:0]         bankFree
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int CNT_W  = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD = CNT_W'(BUSY_CYC - 1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] remain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) remain <= '0;
      else if (accept && acceptBank == BANK_W'(b)) remain <= HOLD;
      else if (remain != '0) remain <= remain - 1'b1;
    end
    assign bankFree[b] = (remain == '0);
  end

  AST_ACCEPT_FREE: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> bankFree[acceptBank]); // R3

  if (BUSY_CYC > 1) begin : g_busyChk
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
      accept |=> !bankFree[$past(acceptBank)]); // R3
  end
endmodule

// File: rtl/lsched_ctrl.sv
module lsched_ctrl
  import lsched_pkg::*;
#(
  parameter int MAX_VL = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [$clog2(MAX_VL+1)-1:0] vecLen,
  input  logic                        bankReady,
  output lschedStrobe_t               strobe,
  output logic [$clog2(MAX_VL)-1:0]   issueIdx
);
  localparam int VL_W  = $clog2(MAX_VL + 1);
  localparam int IDX_W = $clog2(MAX_VL);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t          state;
  logic [VL_W-1:0] idx;
  logic [VL_W-1:0] vlReg;

  always_comb begin
    strobe.load      = start && (state == ST_IDLE) && (vecLen != '0);
    strobe.emptyDone = start && (state == ST_IDLE) && (vecLen == '0);
    strobe.issue     = (state == ST_RUN) && bankReady;
    strobe.lastElem  = strobe.issue && (idx == vlReg - 1'b1);
  end

  assign issueIdx = idx[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      vlReg <= '0;
    end else if (strobe.load) begin
      state <= ST_RUN;
      idx   <= '0;
      vlReg <= vecLen;
    end else if (strobe.issue) begin
      idx <= idx + 1'b1;
      if (strobe.lastElem) state <= ST_IDLE;
    end
  end

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (start && state == ST_IDLE) |-> (vecLen <= VL_W'(MAX_VL))); // R1

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !bankReady) |=> (state == ST_RUN && $stable(idx))); // R3
endmodule

// File: rtl/lsched_dpath.sv
module lsched_dpath
  import lsched_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int NUM_BANKS = 16,
  parameter int BUSY_CYC  = 4,
  parameter int LAT       = 12,
  parameter int IDX_W     = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  lschedStrobe_t                strobe,
  input  logic [IDX_W-1:0]             issueIdx,
  input  logic [ADDR_W-1:0]            baseAddr,
  input  logic [ADDR_W-1:0]            stride,
  output logic                         bankReady,
  output logic                         reqValid,
  output logic [ADDR_W-1:0]            reqAddr,
  output logic [$clog2(NUM_BANKS)-1:0] reqBank,
  input  logic [DATA_W-1:0]            rspData,
  output logic                         elemValid,
  output logic [IDX_W-1:0]             elemIdx,
  output logic [DATA_W-1:0]            elemData,
  output logic                         done
);
  localparam int BANK_W = $clog2(NUM_BANKS);

  logic [ADDR_W-1:0]    curAddr;
  logic [ADDR_W-1:0]    strideReg;
  logic [NUM_BANKS-1:0] bankFree;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      strideReg <= '0;
    end else if (strobe.load) begin
      curAddr   <= baseAddr;
      strideReg <= stride;
    end else if (strobe.issue) begin
      curAddr <= curAddr + strideReg;
    end
  end

  assign reqValid  = strobe.issue;
  assign reqAddr   = curAddr;
  assign reqBank   = curAddr[BANK_W-1:0];
  assign bankReady = bankFree[reqBank];

  lsched_bank_busy #(
    .NUM_BANKS(NUM_BANKS),
    .BUSY_CYC (BUSY_CYC)
  ) u_bankBusy (
    .clk       (clk),
    .rstN      (rstN),
    .accept    (strobe.issue),
    .acceptBank(reqBank),
    .bankFree  (bankFree)
  );

  // Tag pipeline: follows each request through the fixed memory latency
  logic             tagV [LAT];
  logic             tagL [LAT];
  logic [IDX_W-1:0] tagI [LAT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagV[0] <= 1'b0;
      tagL[0] <= 1'b0;
      tagI[0] <= '0;
    end else begin
      tagV[0] <= strobe.issue;
      tagL[0] <= strobe.lastElem;
      tagI[0] <= issueIdx;
    end
  end

  for (genvar k = 1; k < LAT; k++) begin : g_tag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tagV[k] <= 1'b0;
        tagL[k] <= 1'b0;
        tagI[k] <= '0;
      end else begin
        tagV[k] <= tagV[k-1];
        tagL[k] <= tagL[k-1];
        tagI[k] <= tagI[k-1];
      end
    end
  end

  assign elemValid = tagV[LAT-1];
  assign elemIdx   = tagI[LAT-1];
  assign elemData  = rspData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= strobe.emptyDone || (tagV[LAT-1] && tagL[LAT-1]);
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.issue) && !$past(strobe.load) && strobe.issue)
      |-> (reqAddr == ADDR_W'($past(reqAddr) + strideReg))); // R1

  AST_IDX_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(elemValid) && !$past(tagL[LAT-1]) && elemValid)
      |-> (elemIdx == IDX_W'($past(elemIdx) + 1'b1))); // R7
endmodule

// File: rtl/strided_load_sched.sv
module strided_load_sched #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int NUM_BANKS = 16,
  parameter int BUSY_CYC  = 4,
  parameter int LAT       = 12,
  parameter int MAX_VL    = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [ADDR_W-1:0]            baseAddr,
  input  logic [ADDR_W-1:0]            stride,
  input  logic [$clog2(MAX_VL+1)-1:0]  vecLen,
  output logic                         reqValid,
  output logic [ADDR_W-1:0]            reqAddr,
  output logic [$clog2(NUM_BANKS)-1:0] reqBank,
  input  logic [DATA_W-1:0]            rspData,
  output logic                         elemValid,
  output logic [$clog2(MAX_VL)-1:0]    elemIdx,
  output logic [DATA_W-1:0]            elemData,
  output logic                         done
);
  import lsched_pkg::*;

  localparam int IDX_W = $clog2(MAX_VL);

  lschedStrobe_t    strobe;
  logic [IDX_W-1:0] issueIdx;
  logic             bankReady;

  lsched_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .vecLen   (vecLen),
    .bankReady(bankReady),
    .strobe   (strobe),
    .issueIdx (issueIdx)
  );

  lsched_dpath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_BANKS(NUM_BANKS),
    .BUSY_CYC (BUSY_CYC),
    .LAT      (LAT),
    .IDX_W    (IDX_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .issueIdx (issueIdx),
    .baseAddr (baseAddr),
    .stride   (stride),
    .bankReady(bankReady),
    .reqValid (reqValid),
    .reqAddr  (reqAddr),
    .reqBank  (reqBank),
    .rspData  (rspData),
    .elemValid(elemValid),
    .elemIdx  (elemIdx),
    .elemData (elemData),
    .done     (done)
  );
endmodule

// File: tb/strided_load_sched_bench.sv
module strided_load_sched_bench;
  localparam int LAT  = 12;
  localparam int BUSY = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] baseAddr = '0;
  logic [15:0] stride = '0;
  logic [6:0]  vecLen = '0;
  logic        reqValid;
  logic [15:0] reqAddr;
  logic [3:0]  reqBank;
  logic [15:0] rspData;
  logic        elemValid;
  logic [5:0]  elemIdx;
  logic [15:0] elemData;
  logic        done;

  int cyc = 0;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  strided_load_sched u_strided_load_sched (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .stride(stride), .vecLen(vecLen), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqBank(reqBank), .rspData(rspData),
    .elemValid(elemValid), .elemIdx(elemIdx), .elemData(elemData),
    .done(done)
  );

  // Memory model: returns a word derived from the address LAT cycles later
  function automatic logic [15:0] memWord(logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  logic [15:0] memAddr [LAT];
  always @(posedge clk) begin
    memAddr[0] <= reqAddr;
    for (int k = 1; k < LAT; k++) memAddr[k] <= memAddr[k-1];
  end
  assign rspData = memWord(memAddr[LAT-1]);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runVec(input logic [15:0] b, input int s, input int vl,
                        input bit oddStride);
    int expIssue [64];
    logic [15:0] expAddr [64];
    int lastAcc [16];
    int c, prevT, expDone, issueSeen, delivSeen, firstIss, lastIss;
    bit doneSeen;
    logic [15:0] a;
    for (int k = 0; k < 16; k++) lastAcc[k] = -100;
    @(negedge clk);
    c = cyc;
    a = b;
    prevT = c;
    for (int i = 0; i < vl; i++) begin
      int t;
      t = prevT + 1;
      if (lastAcc[a[3:0]] + BUSY > t) t = lastAcc[a[3:0]] + BUSY;
      expIssue[i] = t;
      expAddr[i] = a;
      lastAcc[a[3:0]] = t;
      prevT = t;
      a = a + s[15:0];
    end
    expDone = (vl == 0) ? c + 1 : expIssue[vl-1] + LAT + 1;
    baseAddr = b;
    stride = s[15:0];
    vecLen = 7'(vl);
    start = 1'b1;
    issueSeen = 0; delivSeen = 0; doneSeen = 0; firstIss = 0; lastIss = 0;
    while (!doneSeen && cyc < c + 2000) begin
      @(negedge clk);
      start = 1'b0;
      if (reqValid) begin
        if (issueSeen < vl) begin
          chk(cyc == expIssue[issueSeen], "R3", "issue cycle", cyc, expIssue[issueSeen]);
          chk(reqAddr == expAddr[issueSeen], "R1", "address", reqAddr, expAddr[issueSeen]);
          chk(reqBank == expAddr[issueSeen][3:0], "R2", "bank", reqBank, expAddr[issueSeen][3:0]);
          if (issueSeen == 0) begin
            chk(cyc == c + 1, "R6", "first issue", cyc, c + 1);
            firstIss = cyc;
          end
          lastIss = cyc;
        end else chk(1'b0, "R5", "extra request", issueSeen + 1, vl);
        issueSeen++;
      end
      if (elemValid) begin
        if (delivSeen < vl) begin
          chk(elemIdx == 6'(delivSeen), "R7", "element index", elemIdx, delivSeen);
          chk(elemData == memWord(expAddr[delivSeen]), "R7", "element data",
              elemData, memWord(expAddr[delivSeen]));
          chk(cyc == expIssue[delivSeen] + LAT, "R6", "delivery cycle",
              cyc, expIssue[delivSeen] + LAT);
        end else chk(1'b0, "R7", "extra delivery", delivSeen + 1, vl);
        delivSeen++;
      end
      if (done) begin
        doneSeen = 1'b1;
        chk(cyc == expDone, (vl == 0) ? "R9" : "R8", "done cycle", cyc, expDone);
      end
    end
    chk(doneSeen, "R8", "done seen", doneSeen, 1);
    chk(issueSeen == vl, "R5", "request count", issueSeen, vl);
    chk(delivSeen == vl, "R7", "delivery count", delivSeen, vl);
    if (oddStride && vl > 0)
      chk(lastIss - firstIss == vl - 1, "R4", "issue span", lastIss - firstIss, vl - 1);
    @(negedge clk);
    chk(!done, "R8", "done width", done, 0);
    for (int k = 0; k < 4; k++) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(!reqValid, "R10", "reqValid in reset", reqValid, 0);
    chk(!elemValid, "R10", "elemValid in reset", elemValid, 0);
    chk(!done, "R10", "done in reset", done, 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testUnitStride();   runVec(16'h0100, 1, 20, 1'b1); endtask // R4 R6
  task automatic testOddStride();    runVec(16'h0007, 3, 33, 1'b1); endtask // R4
  task automatic testStride8();      runVec(16'h0040, 8, 10, 1'b0); endtask // R3
  task automatic testStride16();     runVec(16'h0002, 16, 5, 1'b0); endtask // R3
  task automatic testStrideZero();   runVec(16'h0123, 0, 6, 1'b0); endtask  // R3
  task automatic testStride2();      runVec(16'h0000, 2, 12, 1'b0); endtask // R3
  task automatic testNegWrap();      runVec(16'h0005, -1, 64, 1'b1); endtask // R1
  task automatic testSingle();       runVec(16'hFFF0, 5, 1, 1'b1); endtask  // R6 R8
  task automatic testEmpty();        runVec(16'h0200, 1, 0, 1'b0); endtask  // R9

  initial begin
    testReset();
    testUnitStride();
    testOddStride();
    testStride8();
    testStride16();
    testStrideZero();
    testStride2();
    testNegWrap();
    testSingle();
    testEmpty();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc >= 100000);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule